// File: doc/BRIEF.md
# Bitfield Move Execution Unit

This unit is the execute-stage datapath for the bitfield-move instruction family. It takes one 32-bit instruction word and the current contents of the source and destination registers, both 64 bits wide. It decodes the width, variant, N, rotate and top-bit fields. It then lifts a low-order field out of the source and places it in the result. Finally it either sign-extends the field, zero-extends it, or inserts it into the old destination value while leaving the other destination bits alone.

The unit is purely combinational and holds no state. The surrounding pipeline reads both registers using the index outputs. It writes the result back only when the write-enable is high. It routes the undefined flag to its exception logic.

The common shift and extend aliases are encodings of this same family. Logical and arithmetic right shifts, left shifts, and byte or half-word extends therefore need no logic of their own.

Top module: `bfm_unit`

## Requirements
- R1: `rd_idx_o` equals instruction bits 4:0 and `rn_idx_o` equals bits 9:5 for every instruction word.
- R2: Instruction bits 28:23 must equal 6'b100110. Any other value marks the word undefined.
- R3: Bit 31 selects 64-bit operation when 1. A 64-bit word with N (bit 22) equal to 0 is undefined. A 32-bit word is undefined when N is 1, when bit 5 of the rotate field (bits 21:16) is 1, or when bit 5 of the top field (bits 15:10) is 1.
- R4: Bits 30:29 select the variant: 0 signed, 1 insert, 2 unsigned. The value 3 marks the word undefined.
- R5: For an undefined word, `undef_o` is 1, `wr_en_o` is 0 and `result_o` is 0. For any other word, `undef_o` is 0 and `wr_en_o` is 1.
- R6: The unsigned variant with top >= rotate returns source bits top..rotate at result bits (top-rotate)..0, and all other result bits are 0.
- R7: With top < rotate, source bits top..0 land at result bits starting at (datasize-rotate), where datasize is 64 or 32. The result bits below the placed field are 0 for the signed and unsigned variants.
- R8: The signed variant copies the highest placed bit into every result bit above it, up to the datasize. When that bit is bit 63, no bit is padded.
- R9: The insert variant replaces only the placed bit positions of the destination value. All other destination bits pass through unchanged.
- R10: In 32-bit mode, result bits 63:32 are always 0, including in the insert variant when the destination's upper half is nonzero.
- R11: A top field of 63 selects all 64 source bits, so a signed or unsigned move with rotate 0 returns the source unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Instruction word |
| src_i | input | 64 | Current source register value |
| dst_i | input | 64 | Current destination register value (used by insert) |
| result_o | output | 64 | Value to write back |
| wr_en_o | output | 1 | Write-back enable, high for an allocated word |
| undef_o | output | 1 | Undefined-instruction flag |
| rd_idx_o | output | 5 | Destination register index |
| rn_idx_o | output | 5 | Source register index |

## Verification
The hardest case to reach is the wrapped placement, where top < rotate and the highest placed bit falls exactly on the top bit of the data width. In 64-bit mode the padding mask then vanishes. In 32-bit mode the padding is set and then cut off by the upper-half clear. Directed tasks build these words by hand (rotate = top + 1, with the source's low bit set). An exhaustive sweep over every rotate and top pair, for all variants and both widths, also passes through every wrap boundary against a bit-by-bit reference model.

// File: rtl/bfm_pkg.sv
// Shared constants and types for the bitfield move unit.
// Assumes a 64-bit register width and the fixed 32-bit instruction layout.
package bfm_pkg;

    localparam int XLEN    = 64;
    localparam int INSN_W  = 32;
    localparam int IDX_W   = 5;
    localparam int IMM_W   = 6;
    localparam int SHAMT_W = IMM_W + 1;
    localparam int HALF_W  = XLEN / 2;

    // Variant selector taken from bits 30:29
    typedef enum logic [1:0] {
        OP_SIGNED   = 2'd0,
        OP_INSERT   = 2'd1,
        OP_UNSIGNED = 2'd2,
        OP_RSVD     = 2'd3
    } bf_op_e;

    // Decoded instruction fields
    typedef struct packed {
        logic             wide;
        bf_op_e           op;
        logic             n_bit;
        logic [IMM_W-1:0] rot;
        logic [IMM_W-1:0] top;
        logic [IDX_W-1:0] rn;
        logic [IDX_W-1:0] rd;
    } bf_fields_t;

endpackage

// File: rtl/bfm_decode.sv
// Field decoder: slices the instruction word and flags every encoding
// that is outside the bitfield group, reserved, or unallocated.
// Assumes the group pattern sits in bits 28:23.
module bfm_decode
    import bfm_pkg::*;
#(
    parameter logic [5:0] GROUP_CODE = 6'b100110
) (
    input  logic [INSN_W-1:0] insn,
    output bf_fields_t        fld,
    output logic              bad
);

    logic group_miss;
    logic size_rsvd;
    logic op_rsvd;

    // Slice the fixed-position fields
    always_comb begin
        fld.wide  = insn[31];
        fld.op    = bf_op_e'(insn[30:29]);
        fld.n_bit = insn[22];
        fld.rot   = insn[21:16];
        fld.top   = insn[15:10];
        fld.rn    = insn[9:5];
        fld.rd    = insn[4:0];
    end

    // Classify the word as allocated or not
    always_comb begin
        group_miss = (insn[28:23] != GROUP_CODE);
        op_rsvd    = (insn[30:29] == 2'd3);
        if (insn[31]) begin
            size_rsvd = ~insn[22];
        end else begin
            size_rsvd = insn[22] | insn[21] | insn[15];
        end
        bad = group_miss | op_rsvd | size_rsvd;
    end

endmodule

// File: rtl/bfm_place.sv
// Field placement: masks the low (top+1) source bits, then either shifts
// them right by rot or left by (datasize - rot). Also produces the
// positioned mask, the padding mask and the sign-bit index.
// Assumes rot/top already satisfy the width rules (checked by decode).
module bfm_place
    import bfm_pkg::*;
(
    input  logic             wide,
    input  logic [IMM_W-1:0] rot,
    input  logic [IMM_W-1:0] top,
    input  logic [XLEN-1:0]  src,
    output logic [XLEN-1:0]  pos_field,
    output logic [XLEN-1:0]  pos_mask,
    output logic [XLEN-1:0]  pad_mask,
    output logic [IMM_W-1:0] sign_idx
);

    logic [XLEN-1:0]    low_mask;
    logic [XLEN-1:0]    field;
    logic [XLEN-1:0]    raw;
    logic [SHAMT_W-1:0] dsz;
    logic [SHAMT_W-1:0] lsh;
    logic [SHAMT_W-1:0] sidx;
    logic               wrap;

    // Build the low-field mask and the masked source
    always_comb begin
        low_mask = {XLEN{1'b1}} >> (6'd63 - top);
        field    = src & low_mask;
    end

    // Position the field and derive the masks for either placement
    always_comb begin
        wrap = (top < rot);
        dsz  = wide ? SHAMT_W'(XLEN) : SHAMT_W'(HALF_W);
        lsh  = dsz - {1'b0, rot};
        if (!wrap) begin
            raw      = field >> rot;
            pos_mask = low_mask >> rot;
            sidx     = {1'b0, top} - {1'b0, rot};
            pad_mask = ~(low_mask >> rot);
        end else begin
            raw      = field << lsh;
            pos_mask = low_mask << lsh;
            sidx     = dsz + {1'b0, top} - {1'b0, rot};
            pad_mask = {XLEN{1'b1}} << (sidx + 7'd1);
        end
        sign_idx = sidx[IMM_W-1:0];
    end

    // Clear the upper half of the intermediate field in 32-bit mode
    always_comb begin
        pos_field = wide ? raw : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
    end

endmodule

// File: rtl/bfm_merge.sv
// Result merge: applies the variant's rule (sign pad, zero, insert),
// clears the upper half for 32-bit words and forces zero when undefined.
// Assumes inputs from bfm_place and bfm_decode.
module bfm_merge
    import bfm_pkg::*;
(
    input  bf_op_e           op,
    input  logic             wide,
    input  logic             bad,
    input  logic [XLEN-1:0]  pos_field,
    input  logic [XLEN-1:0]  pos_mask,
    input  logic [XLEN-1:0]  pad_mask,
    input  logic [IMM_W-1:0] sign_idx,
    input  logic [XLEN-1:0]  dst,
    output logic [XLEN-1:0]  result
);

    logic            sign_bit;
    logic [XLEN-1:0] merged;

    // Pick out the positioned sign bit
    always_comb begin
        sign_bit = pos_field[sign_idx];
    end

    // Combine according to the variant
    always_comb begin
        unique case (op)
            OP_SIGNED:   merged = sign_bit ? (pos_field | pad_mask) : pos_field;
            OP_INSERT:   merged = (dst & ~pos_mask) | pos_field;
            OP_UNSIGNED: merged = pos_field;
            default:     merged = '0;
        endcase
    end

    // Width clear and undefined suppression
    always_comb begin
        if (bad) begin
            result = '0;
        end else if (!wide) begin
            result = {{HALF_W{1'b0}}, merged[HALF_W-1:0]};
        end else begin
            result = merged;
        end
    end

endmodule

// File: rtl/bfm_unit.sv
// Bitfield move execution unit top: decode, place and merge in one
// combinational path. No clock, no reset, no state.
// Assumes the caller gates write-back with wr_en_o.
module bfm_unit
    import bfm_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    input  logic [XLEN-1:0]   src_i,
    input  logic [XLEN-1:0]   dst_i,
    output logic [XLEN-1:0]   result_o,
    output logic              wr_en_o,
    output logic              undef_o,
    output logic [IDX_W-1:0]  rd_idx_o,
    output logic [IDX_W-1:0]  rn_idx_o
);

    bf_fields_t       fld;
    logic             bad;
    logic [XLEN-1:0]  pos_field;
    logic [XLEN-1:0]  pos_mask;
    logic [XLEN-1:0]  pad_mask;
    logic [IMM_W-1:0] sign_idx;

    bfm_decode #(.GROUP_CODE(6'b100110)) u_decode (
        .insn (insn_i),
        .fld  (fld),
        .bad  (bad)
    );

    bfm_place u_place (
        .wide      (fld.wide),
        .rot       (fld.rot),
        .top       (fld.top),
        .src       (src_i),
        .pos_field (pos_field),
        .pos_mask  (pos_mask),
        .pad_mask  (pad_mask),
        .sign_idx  (sign_idx)
    );

    bfm_merge u_merge (
        .op        (fld.op),
        .wide      (fld.wide),
        .bad       (bad),
        .pos_field (pos_field),
        .pos_mask  (pos_mask),
        .pad_mask  (pad_mask),
        .sign_idx  (sign_idx),
        .dst       (dst_i),
        .result    (result_o)
    );

    // Drive the control outputs
    always_comb begin
        undef_o  = bad;
        wr_en_o  = ~bad;
        rd_idx_o = fld.rd;
        rn_idx_o = fld.rn;
    end

endmodule

// File: rtl/bfm_unit_chk.sv
// Port-level checker for bfm_unit. The unit has no clock, so the checks
// are immediate assertions evaluated whenever the ports settle.
module bfm_unit_chk (
    input logic [31:0] insn_i,
    input logic [63:0] src_i,
    input logic [63:0] result_o,
    input logic        wr_en_o,
    input logic        undef_o,
    input logic [4:0]  rd_idx_o,
    input logic [4:0]  rn_idx_o
);

    // Relate outputs to the instruction word and to each other
    always_comb begin
        a_r5_we_not_undef: assert (wr_en_o != undef_o)
            else $error("R5 write-enable and undefined flag agree");
        a_r5_undef_zero: assert (!undef_o || result_o == 64'd0)
            else $error("R5 nonzero result on undefined word");
        a_r4_opc3_undef: assert (insn_i[30:29] != 2'd3 || undef_o)
            else $error("R4 opcode 3 not flagged");
        a_r3_wide_n_low: assert (!(insn_i[31] && !insn_i[22]) || undef_o)
            else $error("R3 64-bit word with N=0 not flagged");
        a_r10_upper_zero: assert (insn_i[31] || result_o[63:32] == 32'd0)
            else $error("R10 upper half set in 32-bit mode");
        a_r1_indices: assert (rd_idx_o == insn_i[4:0] && rn_idx_o == insn_i[9:5])
            else $error("R1 register index mismatch");
        a_r11_identity: assert (!(wr_en_o && insn_i[31] && insn_i[30:29] != 2'd1
                                  && insn_i[21:10] == 12'h03F) || result_o == src_i)
            else $error("R11 full-width move altered source");
    end

endmodule

bind bfm_unit bfm_unit_chk u_chk (
    .insn_i   (insn_i),
    .src_i    (src_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .undef_o  (undef_o),
    .rd_idx_o (rd_idx_o),
    .rn_idx_o (rn_idx_o)
);

// File: tb/bfm_unit_bench.sv
module bfm_unit_bench;

    logic        clk;
    logic        rst_n;
    logic [31:0] insn;
    logic [63:0] src;
    logic [63:0] dst;
    logic [63:0] result;
    logic        wr_en;
    logic        undef;
    logic [4:0]  rd_idx;
    logic [4:0]  rn_idx;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    bfm_unit u_bfm_unit (
        .insn_i   (insn),
        .src_i    (src),
        .dst_i    (dst),
        .result_o (result),
        .wr_en_o  (wr_en),
        .undef_o  (undef),
        .rd_idx_o (rd_idx),
        .rn_idx_o (rn_idx)
    );

    // 250 MHz clock
    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [31:0] mk(input logic sf, input logic [1:0] opc,
                                       input logic n, input logic [5:0] immr,
                                       input logic [5:0] imms, input logic [4:0] rn,
                                       input logic [4:0] rd);
        return {sf, opc, 6'b100110, n, immr, imms, rn, rd};
    endfunction

    // Bit-by-bit reference: returns {undef, result}
    function automatic logic [64:0] ref_model(input logic [31:0] w,
                                              input logic [63:0] s,
                                              input logic [63:0] d);
        logic [63:0] r;
        logic        wide = w[31];
        logic [1:0]  op   = w[30:29];
        int rot = int'(w[21:16]);
        int tp  = int'(w[15:10]);
        int ds  = wide ? 64 : 32;
        int hi;
        if (w[28:23] != 6'b100110 || op == 2'd3 || (wide && !w[22]) ||
            (!wide && (w[22] || w[21] || w[15])))
            return {1'b1, 64'd0};
        r = (op == 2'd1) ? d : 64'd0;
        if (tp >= rot) begin
            for (int k = rot; k <= tp; k++) r[k - rot] = s[k];
            hi = tp - rot;
        end else begin
            for (int k = 0; k <= tp; k++) r[ds - rot + k] = s[k];
            hi = ds - rot + tp;
        end
        if (op == 2'd0 && r[hi])
            for (int b = hi + 1; b < ds; b++) r[b] = 1'b1;
        if (!wide) r[63:32] = 32'd0;
        return {1'b0, r};
    endfunction

    task automatic apply(input logic [31:0] w, input logic [63:0] s, input logic [63:0] d);
        @(posedge clk);
        #1;
        insn = w;
        src  = s;
        dst  = d;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    // Compare all outputs with the reference, plus optional hand value
    task automatic check_ref(input string req, input logic [31:0] w,
                             input logic [63:0] s, input logic [63:0] d);
        logic [64:0] e;
        apply(w, s, d);
        e = ref_model(w, s, d);
        check(req, {undef, wr_en, result}, {e[64], ~e[64], e[63:0]});
    endtask

    task automatic check_hand(input string req, input logic [31:0] w,
                              input logic [63:0] s, input logic [63:0] d,
                              input logic [63:0] exp);
        apply(w, s, d);
        check(req, {undef, wr_en, result}, {1'b0, 1'b1, exp});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        apply(32'd0, 64'd0, 64'd0);
        check("R2 R5 reset idle word", {undef, wr_en, result}, {1'b1, 1'b0, 64'd0});
        rst_n = 1'b1;
    endtask

    task automatic t_indices;
        apply(mk(1, 2, 1, 6'd3, 6'd9, 5'd17, 5'd30), 64'd0, 64'd0);
        check("R1 indices a", {56'd0, rn_idx, rd_idx}, {56'd0, 5'd17, 5'd30});
        apply(mk(0, 3, 0, 6'd0, 6'd0, 5'd1, 5'd31), 64'd0, 64'd0);
        check("R1 indices on undefined", {56'd0, rn_idx, rd_idx}, {56'd0, 5'd1, 5'd31});
    endtask

    task automatic t_group;
        apply(mk(1, 2, 1, 6'd0, 6'd7, 0, 0) ^ (32'h1 << 25), 64'hFF, 64'd0);
        check("R2 group mismatch", {undef, wr_en, result}, {1'b1, 1'b0, 64'd0});
    endtask

    task automatic t_reserved;
        apply(mk(1, 2, 0, 6'd0, 6'd7, 0, 0), 64'hFF, 64'hFF);
        check("R3 64-bit N=0", {undef, wr_en, result}, {1'b1, 1'b0, 64'd0});
        apply(mk(0, 2, 1, 6'd0, 6'd7, 0, 0), 64'hFF, 64'hFF);
        check("R3 32-bit N=1", {undef, wr_en, result}, {1'b1, 1'b0, 64'd0});
        apply(mk(0, 1, 0, 6'd32, 6'd7, 0, 0), 64'hFF, 64'hFF);
        check("R3 32-bit rotate bit5", {undef, wr_en, result}, {1'b1, 1'b0, 64'd0});
        apply(mk(0, 0, 0, 6'd0, 6'd40, 0, 0), 64'hFF, 64'hFF);
        check("R3 32-bit top bit5", {undef, wr_en, result}, {1'b1, 1'b0, 64'd0});
    endtask

    task automatic t_opc3;
        apply(mk(1, 3, 1, 6'd0, 6'd7, 0, 0), 64'hFF, 64'hFF);
        check("R4 R5 opcode 3", {undef, wr_en, result}, {1'b1, 1'b0, 64'd0});
    endtask

    task automatic t_unsigned;
        check_hand("R6 unsigned extract", mk(1, 2, 1, 6'd8, 6'd15, 0, 0),
                   64'h1234_5678_9ABC_DEF0, 64'hFFFF, 64'h0000_0000_0000_00DE);
        check_hand("R7 unsigned left shift 4", mk(1, 2, 1, 6'd60, 6'd59, 0, 0),
                   64'h1234_5678_9ABC_DEF0, 64'd0, 64'h2345_6789_ABCD_EF00);
        check_hand("R6 unsigned top equals rotate", mk(1, 2, 1, 6'd5, 6'd5, 0, 0),
                   64'h20, 64'd0, 64'h1);
    endtask

    task automatic t_signed;
        check_hand("R8 signed byte", mk(1, 0, 1, 6'd0, 6'd7, 0, 0),
                   64'h80, 64'd0, 64'hFFFF_FFFF_FFFF_FF80);
        check_hand("R8 sign at bit 63 no pad", mk(1, 0, 1, 6'd1, 6'd0, 0, 0),
                   64'h1, 64'd0, 64'h8000_0000_0000_0000);
        check_hand("R8 R10 32-bit sign at bit 31", mk(0, 0, 0, 6'd1, 6'd0, 0, 0),
                   64'h1, 64'd0, 64'h0000_0000_8000_0000);
        check_hand("R7 signed wrap low zero", mk(1, 0, 1, 6'd60, 6'd1, 0, 0),
                   64'h3, 64'd0, 64'hFFFF_FFFF_FFFF_FFF0);
    endtask

    task automatic t_insert;
        check_hand("R9 insert byte at 8", mk(1, 1, 1, 6'd56, 6'd7, 0, 0),
                   64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_00FF);
        check_hand("R9 insert low extract", mk(1, 1, 1, 6'd4, 6'd11, 0, 0),
                   64'hABC0, 64'h1111_1111_1111_1111, 64'h1111_1111_1111_11BC);
    endtask

    task automatic t_wide32;
        check_hand("R10 32-bit insert clears upper", mk(0, 1, 0, 6'd0, 6'd3, 0, 0),
                   64'h5, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_FFFF_FFF5);
        check_hand("R10 32-bit unsigned full", mk(0, 2, 0, 6'd0, 6'd31, 0, 0),
                   64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'h0000_0000_FFFF_FFFF);
    endtask

    task automatic t_full;
        check_hand("R11 signed full width", mk(1, 0, 1, 6'd0, 6'd63, 0, 0),
                   64'h8765_4321_0FED_CBA9, 64'd0, 64'h8765_4321_0FED_CBA9);
        check_hand("R11 arithmetic shift 4", mk(1, 0, 1, 6'd4, 6'd63, 0, 0),
                   64'h8000_0000_0000_0000, 64'd0, 64'hF800_0000_0000_0000);
    endtask

    // Exhaustive rotate/top sweep for every variant and both widths
    task automatic t_sweep;
        for (int sf = 0; sf < 2; sf++) begin
            for (int op = 0; op < 3; op++) begin
                for (int r = 0; r < 64; r++) begin
                    for (int t = 0; t < 64; t++) begin
                        seed = seed ^ (seed << 13);
                        seed = seed ^ (seed >> 7);
                        seed = seed ^ (seed << 17);
                        check_ref("R6 R7 R8 R9 R10 sweep",
                                  mk(sf[0], op[1:0], sf[0], r[5:0], t[5:0], 5'd2, 5'd3),
                                  seed, ~{seed[31:0], seed[63:32]});
                    end
                end
            end
        end
    endtask

    initial begin
        rst_n = 1'b0;
        insn  = '0;
        src   = '0;
        dst   = '0;
        t_reset();
        t_indices();
        t_group();
        t_reserved();
        t_opc3();
        t_unsigned();
        t_signed();
        t_insert();
        t_wide32();
        t_full();
        t_sweep();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule